// File: doc/BRIEF.md
# HDLC Receive Pool and Interrupt Controller

This block sits between an HDLC receive deframer and the processor. The deframer reports a frame start, then one data byte per strobe, then an end of frame. Flags, destuffing and CRC are already handled upstream. The block decides whether each frame is accepted and stores the bytes of accepted frames in a 64-entry FIFO. After the last byte it adds one status entry. The block raises three sticky interrupt causes, each with its own mask, and combines them onto one interrupt line. The causes are: early frame start, 32-byte pool full, and byte lost to overflow.

The line side has no back-pressure, because a serial line cannot be made to wait. The input therefore carries a valid strobe and no ready signal. A byte that arrives while the FIFO holds all 64 entries is dropped and reported. The read side is a valid/ready stream. An entry leaves only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head entry and `out_valid` hold steady.

There are two qualification modes. In transparent mode, every frame is accepted from its start. In address mode, the first byte of a frame is the address. The frame is kept only if the address-match input is high with that byte.

Top module: `hdlc_rx_pool`

## Requirements
- R1: Bytes of an accepted frame leave `out_data` in arrival order. A data entry has bit 12 at 0 and the byte in bits 7:0. An entry is removed only on a cycle with `out_valid` and `out_ready` both high; otherwise the head is held.
- R2: When `addr_mode` is 0 at frame start, the frame is accepted from `in_sof` on. `frame_addr` shows the first byte of the frame from the cycle after that byte.
- R3: When `addr_mode` is 1 at frame start, the first byte decides acceptance. If `in_addr_match` is high with it, the byte is stored and the frame is accepted. If not, no byte, status entry or interrupt results from the frame, whatever the match input does later.
- R4: `irq_status[0]` (frame start) sets after the second byte that arrives once the frame is already accepted. That is the 2nd byte in transparent mode and the 3rd byte in address mode. It is not set earlier, and it is set at most once per frame.
- R5: `irq_status[1]` (pool full) sets when the 32nd byte stored since frame start, or since the previous pool event, enters the FIFO.
- R6: A byte of an accepted frame that arrives while the FIFO holds 64 entries is discarded. `irq_status[2]` (overflow) is set in the following cycle.
- R7: After an overflow, the frame is still received. Its later bytes are stored as soon as entries have been read out.
- R8: At end of an accepted frame, a status entry is written. It has bit 12 at 1, bit 11 at 1 if any byte of that frame was lost, and bits 10:0 holding the count of that frame's bytes (stored or lost), saturating. If the FIFO is full at that moment, the entry is lost and overflow is signalled.
- R9: The per-frame loss flag in a status entry depends only on its own frame. A later frame without loss carries flag 0 while `irq_status[2]` stays set.
- R10: Status bits are sticky. A one-cycle `stat_rd` clears them. A cause that occurs in the same cycle as `stat_rd` leaves its bit set.
- R11: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 1. Masked causes are still recorded in `irq_status`.
- R12: After reset, the FIFO is empty, `irq_status` is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_mode | input | 1 | 1 selects address qualification; sampled at frame start |
| in_sof | input | 1 | Frame start strobe |
| in_valid | input | 1 | Data byte strobe |
| in_data | input | 8 | Received byte |
| in_addr_match | input | 1 | Address match, meaningful with the first byte |
| in_eof | input | 1 | End of frame strobe |
| frame_addr | output | 8 | First byte of the current frame |
| out_valid | output | 1 | FIFO head entry is present |
| out_ready | input | 1 | Reader takes the head entry |
| out_data | output | 13 | Head entry: data byte or frame status |
| irq_mask | input | 3 | Per-cause enable: bit0 start, bit1 pool, bit2 overflow |
| stat_rd | input | 1 | Status read strobe, clears sticky bits |
| irq_status | output | 3 | Sticky causes: bit0 start, bit1 pool, bit2 overflow |
| irq | output | 1 | Masked interrupt request |

## Verification
The frame-start and pool counters are checked byte by byte. A wrong count moves the matching status bit by at least one byte, and that shows on `irq_status` one cycle after the byte concerned. A wrong loss flag or byte count stays hidden until the status entry reaches the FIFO head, which can be dozens of cycles later. Each frame is therefore drained to its status entry, and every entry is compared. A FIFO that accepts a write while full corrupts the order of later bytes. This is caught when the bytes that follow an overflow are read back.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int BYTE_W = 8;
  localparam int IRQ_N  = 3;

  // Bit positions of the interrupt causes in the status vector
  typedef enum logic [1:0] {
    IRQ_START = 2'd0,
    IRQ_POOL  = 2'd1,
    IRQ_OVF   = 2'd2
  } irq_bit_e;

  // Status payload: loss flag above the count, at least one byte wide
  function automatic int stat_width(input int cnt_w);
    return (cnt_w + 1 > BYTE_W) ? cnt_w + 1 : BYTE_W;
  endfunction
endpackage

// File: rtl/hrp_fifo.sv
module hrp_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [FW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign full    = (fill == FW'(DEPTH));
  assign empty   = (fill == '0);
  assign push    = wr_en & ~full;
  assign pop     = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/hrp_frame_ctl.sv
module hrp_frame_ctl
  import hrp_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int POOL   = 32,
  parameter int ENT_W  = 13,
  localparam int STAT_W = ENT_W - 1,
  localparam int PW     = $clog2(POOL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_mode,
  input  logic              sof,
  input  logic              byte_v,
  input  logic [BYTE_W-1:0] byte_d,
  input  logic              addr_match,
  input  logic              eof,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [ENT_W-1:0]  wr_data,
  output logic              ev_start,
  output logic              ev_pool,
  output logic              ev_ovf,
  output logic [BYTE_W-1:0] frame_addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              active_q, first_q, mode_q, qual_q;
  logic              since_q, started_q, lost_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PW-1:0]     pool_q;
  logic [BYTE_W-1:0] addr_q;
  logic              take, store, lost_byte, close, push_stat;
  logic [STAT_W-1:0] stat_word;

  // A byte belongs to the frame if the frame is accepted, or if it is the
  // matching address byte that accepts it now
  assign take      = byte_v & active_q & (qual_q | (first_q & mode_q & addr_match));
  assign store     = take & ~fifo_full;
  assign lost_byte = take & fifo_full;
  assign close     = eof & active_q & qual_q;
  assign push_stat = close & ~fifo_full;

  assign wr_en    = store | push_stat;
  assign ev_pool  = store & (pool_q == PW'(POOL - 1));
  assign ev_start = take & qual_q & since_q & ~started_q;
  assign ev_ovf   = lost_byte | (close & fifo_full);
  assign frame_addr = addr_q;

  always_comb begin
    stat_word            = '0;
    stat_word[CNT_W-1:0] = cnt_q;
    stat_word[CNT_W]     = lost_q;
    wr_data              = '0;
    if (close) wr_data = {1'b1, stat_word};
    else       wr_data[BYTE_W-1:0] = byte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      first_q   <= 1'b0;
      mode_q    <= 1'b0;
      qual_q    <= 1'b0;
      since_q   <= 1'b0;
      started_q <= 1'b0;
      lost_q    <= 1'b0;
      cnt_q     <= '0;
      pool_q    <= '0;
      addr_q    <= '0;
    end else if (sof) begin
      active_q  <= 1'b1;
      first_q   <= 1'b1;
      mode_q    <= addr_mode;
      qual_q    <= ~addr_mode;
      since_q   <= 1'b0;
      started_q <= 1'b0;
      lost_q    <= 1'b0;
      cnt_q     <= '0;
      pool_q    <= '0;
    end else if (eof && active_q) begin
      active_q <= 1'b0;
      qual_q   <= 1'b0;
    end else if (byte_v && active_q) begin
      if (first_q) begin
        first_q <= 1'b0;
        addr_q  <= byte_d;
        if (mode_q && !addr_match) active_q <= 1'b0;
        else                       qual_q   <= 1'b1;
      end
      if (take) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (lost_byte) lost_q <= 1'b1;
        if (store) pool_q <= ev_pool ? '0 : pool_q + 1'b1;
        if (qual_q) since_q <= 1'b1;
        if (ev_start) started_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hrp_irq_regs.sv
module hrp_irq_regs #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         rd,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  // A new cause beats a simultaneous read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (rd ? '0 : status) | ev;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
  import hrp_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int POOL_BYTES = 32,
  parameter int CNT_W      = 11,
  localparam int STAT_W    = hrp_pkg::stat_width(CNT_W),
  localparam int ENT_W     = STAT_W + 1,
  localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_mode,
  input  logic              in_sof,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_addr_match,
  input  logic              in_eof,
  output logic [BYTE_W-1:0] frame_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ENT_W-1:0]  out_data,
  input  logic [IRQ_N-1:0]  irq_mask,
  input  logic              stat_rd,
  output logic [IRQ_N-1:0]  irq_status,
  output logic              irq
);
  logic              fifo_wr, fifo_full, fifo_empty;
  logic [ENT_W-1:0]  fifo_wdata;
  logic [FILL_W-1:0] fill;
  logic              ev_start, ev_pool, ev_ovf;
  logic [IRQ_N-1:0]  ev_vec;

  hrp_frame_ctl #(.CNT_W(CNT_W), .POOL(POOL_BYTES), .ENT_W(ENT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .sof(in_sof),
    .byte_v(in_valid), .byte_d(in_data), .addr_match(in_addr_match),
    .eof(in_eof), .fifo_full(fifo_full), .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .ev_start(ev_start), .ev_pool(ev_pool), .ev_ovf(ev_ovf),
    .frame_addr(frame_addr)
  );

  hrp_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .rd_en(out_ready), .rd_data(out_data), .empty(fifo_empty),
    .full(fifo_full), .fill(fill)
  );

  assign out_valid = ~fifo_empty;

  always_comb begin
    ev_vec            = '0;
    ev_vec[IRQ_START] = ev_start;
    ev_vec[IRQ_POOL]  = ev_pool;
    ev_vec[IRQ_OVF]   = ev_ovf;
  end

  hrp_irq_regs #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .rd(stat_rd),
    .mask(irq_mask), .status(irq_status), .irq(irq)
  );
endmodule

// File: rtl/hrp_chk.sv
module hrp_chk #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 13,
  parameter int FW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_wr,
  input logic             fifo_full,
  input logic [FW-1:0]    fill,
  input logic             ev_start,
  input logic             ev_pool,
  input logic             ev_ovf,
  input logic             stat_rd,
  input logic [2:0]       irq_status,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ENT_W-1:0] out_data
);
  // R6
  ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> irq_status[2]);

  // R6
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R1
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

  // R5
  pool_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pool |-> fifo_wr);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> irq_status[0]);
endmodule

bind hdlc_rx_pool hrp_chk #(.DEPTH(FIFO_DEPTH), .ENT_W(ENT_W), .FW(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_full(fifo_full),
  .fill(fill), .ev_start(ev_start), .ev_pool(ev_pool), .ev_ovf(ev_ovf),
  .stat_rd(stat_rd), .irq_status(irq_status), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/hdlc_rx_pool_tb.sv
module hdlc_rx_pool_tb;
  logic        clk = 1'b0;
  logic        rst_n, addr_mode, in_sof, in_valid, in_addr_match, in_eof;
  logic [7:0]  in_data, frame_addr;
  logic        out_valid, out_ready, stat_rd, irq;
  logic [12:0] out_data;
  logic [2:0]  irq_mask, irq_status;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hdlc_rx_pool u_dut (
    .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .in_sof(in_sof),
    .in_valid(in_valid), .in_data(in_data), .in_addr_match(in_addr_match),
    .in_eof(in_eof), .frame_addr(frame_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .irq_mask(irq_mask),
    .stat_rd(stat_rd), .irq_status(irq_status), .irq(irq)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; return at the next one
  task automatic step(input logic sof, input logic v, input logic [7:0] d,
                      input logic m, input logic eof, input logic rd);
    in_sof = sof; in_valid = v; in_data = d; in_addr_match = m;
    in_eof = eof; stat_rd = rd;
    @(negedge clk);
    in_sof = 0; in_valid = 0; in_data = 0; in_addr_match = 0;
    in_eof = 0; stat_rd = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic m, input logic rd);
    step(0, 1, d, m, 0, rd);
  endtask

  task automatic clear_irq();
    step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic pop_chk(input string req, input int exp);
    chk_eq(req, out_valid ? int'(out_data) : -1, exp);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset();
    chk_eq("R12 status", int'(irq_status), 0);
    chk_eq("R12 empty", int'(out_valid), 0);
    chk_eq("R12 irq", int'(irq), 0);
  endtask

  task automatic t_transparent();
    addr_mode = 0;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    send(8'h31, 0, 0);
    chk_eq("R4 no start after byte 1", int'(irq_status[0]), 0);
    chk_eq("R2 frame_addr", int'(frame_addr), 'h31);
    send(8'h32, 0, 0);
    chk_eq("R4 start after byte 2", int'(irq_status[0]), 1);
    chk_eq("R11 irq unmasked", int'(irq), 1);
    send(8'h33, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    chk_eq("R1 head held", int'(out_data), 'h31);
    pop_chk("R1 byte0", 'h31);
    pop_chk("R1 byte1", 'h32);
    pop_chk("R1 byte2", 'h33);
    pop_chk("R8 status", 'h1003);
    chk_eq("R1 drained", int'(out_valid), 0);
  endtask

  task automatic t_addr_match();
    addr_mode = 1;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    send(8'hA5, 1, 0);
    chk_eq("R3 address captured", int'(frame_addr), 'hA5);
    send(8'h11, 0, 0);
    chk_eq("R4 no start after byte 2 in addr mode", int'(irq_status[0]), 0);
    send(8'h22, 0, 1);
    chk_eq("R10 set beats read", int'(irq_status), 1);
    step(0, 0, 0, 0, 1, 0);
    pop_chk("R3 addr byte stored", 'hA5);
    pop_chk("R3 byte1", 'h11);
    pop_chk("R3 byte2", 'h22);
    pop_chk("R8 status", 'h1003);
  endtask

  task automatic t_addr_miss();
    addr_mode = 1;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    send(8'h5A, 0, 0);
    send(8'h11, 1, 0);
    send(8'h22, 1, 0);
    send(8'h33, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    chk_eq("R3 rejected frame stores nothing", int'(out_valid), 0);
    chk_eq("R3 rejected frame no irq", int'(irq_status), 0);
  endtask

  task automatic t_pool();
    addr_mode = 0;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      send(8'(8'h80 + i), 0, 0);
      if (i == 30) chk_eq("R5 no pool at 31", int'(irq_status[1]), 0);
      if (i == 31) begin
        chk_eq("R5 pool at 32", int'(irq_status[1]), 1);
        clear_irq();
      end
      if (i == 39) chk_eq("R5 no pool at 40", int'(irq_status[1]), 0);
    end
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) pop_chk("R1 pool frame byte", 'h80 + i);
    pop_chk("R8 status 40", 'h1028);
  endtask

  task automatic t_overflow();
    addr_mode = 0;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) begin
      send(8'(i), 0, 0);
      if (i == 63) chk_eq("R6 no ovf at 64", int'(irq_status[2]), 0);
      if (i == 64) chk_eq("R6 ovf at 65", int'(irq_status[2]), 1);
    end
    for (int i = 0; i < 10; i++) pop_chk("R6 kept byte", i);
    send(8'd70, 0, 0);
    send(8'd71, 0, 0);
    send(8'd72, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 10; i < 64; i++) pop_chk("R6 kept byte", i);
    pop_chk("R7 resumed 70", 70);
    pop_chk("R7 resumed 71", 71);
    pop_chk("R7 resumed 72", 72);
    pop_chk("R8 status lost", 'h1849);
  endtask

  task automatic t_frame_flag();
    addr_mode = 0;
    step(1, 0, 0, 0, 0, 0);
    send(8'h01, 0, 0);
    send(8'h02, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    pop_chk("R9 byte0", 1);
    pop_chk("R9 byte1", 2);
    pop_chk("R9 clean status", 'h1002);
    chk_eq("R9 global ovf kept", int'(irq_status[2]), 1);
  endtask

  task automatic t_mask();
    addr_mode = 0;
    clear_irq();
    step(1, 0, 0, 0, 0, 0);
    send(8'h07, 0, 0);
    send(8'h08, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    pop_chk("R11 byte0", 7);
    pop_chk("R11 byte1", 8);
    pop_chk("R11 status", 'h1002);
    irq_mask = 3'b000; #1;
    chk_eq("R11 masked irq", int'(irq), 0);
    chk_eq("R11 masked recorded", int'(irq_status), 1);
    irq_mask = 3'b001; #1;
    chk_eq("R11 enabled irq", int'(irq), 1);
    irq_mask = 3'b110; #1;
    chk_eq("R11 other bits masked", int'(irq), 0);
    irq_mask = 3'b111;
    @(negedge clk);
    clear_irq();
    chk_eq("R10 cleared by read", int'(irq_status), 0);
    chk_eq("R10 irq low", int'(irq), 0);
  endtask

  initial begin
    rst_n = 0; addr_mode = 0; in_sof = 0; in_valid = 0; in_data = 0;
    in_addr_match = 0; in_eof = 0; out_ready = 0; stat_rd = 0;
    irq_mask = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_transparent();
    t_addr_match();
    t_addr_miss();
    t_pool();
    t_overflow();
    t_frame_flag();
    t_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule